// File: doc/BRIEF.md
# Register Command Decoder with Edge Counters

This block sits behind a host byte pipe and turns the incoming stream into register accesses. Bytes pair up into 16-bit little-endian words, and the first word of each command is its identifier. Two identifiers are executed locally. A register read takes one address word and answers with four bytes. A register write takes an address word and two data words, and it sends no reply. Thirty-two-bit values travel with the upper half first, and each half is little-endian.

The register file holds three read-only identity constants and a capture-size value that comes in from a port. It also holds three plain read/write registers, whose values are driven out to the rest of the chip. Four per-channel rising-edge counters clear themselves in the same cycle that they are read.

Two further identifiers, the memory-read and the status-poll commands, are not executed here. The block announces them on a forwarding port and passes their argument words through. Any other identifier raises a one-cycle error pulse, and the parser then returns to idle.

Top module: `regcmd_decoder`

## Requirements
- R1: Input bytes pair into 16-bit words with the first byte as bits 7:0. The first word after idle is taken as the command identifier.
- R2: Identifier 0x0001 followed by an address word yields exactly four response bytes on consecutive cycles. The first response byte appears in the cycle after the address word is complete.
- R3: Write data and read responses carry a 32-bit value as the byte sequence d[23:16], d[31:24], d[7:0], d[15:8].
- R4: Identifier 0x0002 followed by an address word and two data words performs a write and produces no response byte.
- R5: Addresses 0x10B4, 0x1074 and 0x107C are read/write registers that reset to zero. Their values appear on user_reg0, user_reg1 and user_reg2.
- R6: Addresses 0x10B0 and 0x10BC read 0x12345678, and address 0x10B8 reads 0x87654321. Writes to these three addresses are ignored.
- R7: Address 0x1078 reads the cap_size input. Writes to it are ignored.
- R8: The counter at address 0x10C0+4*i counts rising edges of ch_in[i], which is synchronized through two flops. Writes to the counter addresses are ignored.
- R9: Reading a counter returns its value and clears it. A rising edge that is detected in the same cycle as the clearing read leaves the counter at 1.
- R10: Reading any unmapped address returns zero. Writing to an unmapped address changes no register.
- R11: For identifier 0x0006 or 0x0008, the block gives one fwd_start pulse carrying the identifier on fwd_id. It then passes the next 4 words (for 0x0006) or 2 words (for 0x0008) out as fwd_word_vld pulses and returns to idle.
- R12: Any other identifier gives a one-cycle err pulse, and the next word is treated as a new identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte strobe |
| in_byte | input | 8 | Input byte |
| ch_in | input | NCH | Asynchronous channel inputs for the counters |
| cap_size | input | 32 | Capture size in 36-bit words |
| rsp_valid | output | 1 | Response byte strobe |
| rsp_byte | output | 8 | Response byte |
| err | output | 1 | Unknown-identifier pulse |
| fwd_start | output | 1 | Forwarded command start pulse |
| fwd_id | output | 16 | Identifier of the forwarded command |
| fwd_word_vld | output | 1 | Forwarded argument word strobe |
| fwd_word | output | 16 | Forwarded argument word |
| user_reg0 | output | 32 | Register at 0x10B4 |
| user_reg1 | output | 32 | Register at 0x1074 |
| user_reg2 | output | 32 | Register at 0x107C |

## Verification
Two functions can land in the same cycle: a counter's read-clear and a rising edge on that counter's channel. The bench provokes this by raising the channel together with the low address byte of a read. With that timing, the synchronized edge is detected exactly when the read is decoded. The returned value must then equal the count taken before the edge, and a second read must return 1. A control case raises the channel one byte earlier; there the edge is counted before the clear, the first read returns one more, and the second read returns 0.

// File: rtl/regcmd_pkg.sv
package regcmd_pkg;

  localparam logic [15:0] CMD_RD   = 16'h0001;
  localparam logic [15:0] CMD_WR   = 16'h0002;
  localparam logic [15:0] CMD_MEM  = 16'h0006;
  localparam logic [15:0] CMD_POLL = 16'h0008;

  localparam int FWD_CNT_W = 3;
  localparam logic [FWD_CNT_W-1:0] MEM_ARGS  = 3'd4;
  localparam logic [FWD_CNT_W-1:0] POLL_ARGS = 3'd2;

  localparam logic [15:0] ADDR_IDA0 = 16'h10B0;
  localparam logic [15:0] ADDR_IDB  = 16'h10B8;
  localparam logic [15:0] ADDR_IDA1 = 16'h10BC;
  localparam logic [15:0] ADDR_CAP  = 16'h1078;
  localparam logic [15:0] ADDR_UR0  = 16'h10B4;
  localparam logic [15:0] ADDR_UR1  = 16'h1074;
  localparam logic [15:0] ADDR_UR2  = 16'h107C;
  localparam logic [15:0] ADDR_CNT0 = 16'h10C0;

  localparam logic [31:0] ID_VAL_A = 32'h1234_5678;
  localparam logic [31:0] ID_VAL_B = 32'h8765_4321;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ADDR,
    ST_WR_ADDR,
    ST_WR_DHI,
    ST_WR_DLO,
    ST_FWD
  } parse_st_e;

  // Byte lane for response beat idx: upper half first, each half low byte first
  function automatic logic [7:0] lane_byte(input logic [31:0] d, input logic [1:0] idx);
    logic [7:0] b;
    case (idx)
      2'd0:    b = d[23:16];
      2'd1:    b = d[31:24];
      2'd2:    b = d[7:0];
      default: b = d[15:8];
    endcase
    return b;
  endfunction

endpackage

// File: rtl/regcmd_word_asm.sv
module regcmd_word_asm (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [7:0]  in_byte,
  output logic        word_vld,
  output logic [15:0] word
);

  logic        phase_q, phase_d;
  logic [7:0]  lo_q, lo_d;
  logic        vld_q, vld_d;
  logic [15:0] word_q, word_d;

  always_comb begin
    phase_d = phase_q;
    lo_d    = lo_q;
    word_d  = word_q;
    vld_d   = 1'b0;
    if (in_valid) begin
      if (!phase_q) begin
        lo_d    = in_byte;
        phase_d = 1'b1;
      end else begin
        word_d  = {in_byte, lo_q};
        vld_d   = 1'b1;
        phase_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      lo_q    <= '0;
      vld_q   <= 1'b0;
      word_q  <= '0;
    end else begin
      phase_q <= phase_d;
      lo_q    <= lo_d;
      vld_q   <= vld_d;
      word_q  <= word_d;
    end
  end

  assign word_vld = vld_q;
  assign word     = word_q;

  AST_WORD_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> $past(in_valid)); // R1

endmodule

// File: rtl/regcmd_parser.sv
module regcmd_parser
  import regcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        word_vld,
  input  logic [15:0] word,
  output logic        rd_en,
  output logic [15:0] rd_addr,
  output logic        wr_en,
  output logic [15:0] wr_addr,
  output logic [31:0] wr_data,
  output logic        err,
  output logic        fwd_start,
  output logic [15:0] fwd_id,
  output logic        fwd_word_vld,
  output logic [15:0] fwd_word
);

  parse_st_e            state_q, state_d;
  logic [15:0]          addr_q, addr_d;
  logic [15:0]          hi_q, hi_d;
  logic [FWD_CNT_W-1:0] left_q, left_d;
  logic                 err_q, err_d;
  logic                 fs_q, fs_d;
  logic [15:0]          fid_q, fid_d;
  logic                 fwv_q, fwv_d;
  logic [15:0]          fw_q, fw_d;

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    hi_d    = hi_q;
    left_d  = left_q;
    err_d   = 1'b0;
    fs_d    = 1'b0;
    fid_d   = fid_q;
    fwv_d   = 1'b0;
    fw_d    = fw_q;
    rd_en   = 1'b0;
    wr_en   = 1'b0;
    if (word_vld) begin
      case (state_q)
        ST_IDLE: begin
          case (word)
            CMD_RD: state_d = ST_RD_ADDR;
            CMD_WR: state_d = ST_WR_ADDR;
            CMD_MEM: begin
              fs_d    = 1'b1;
              fid_d   = word;
              left_d  = MEM_ARGS;
              state_d = ST_FWD;
            end
            CMD_POLL: begin
              fs_d    = 1'b1;
              fid_d   = word;
              left_d  = POLL_ARGS;
              state_d = ST_FWD;
            end
            default: err_d = 1'b1;
          endcase
        end
        ST_RD_ADDR: begin
          rd_en   = 1'b1;
          state_d = ST_IDLE;
        end
        ST_WR_ADDR: begin
          addr_d  = word;
          state_d = ST_WR_DHI;
        end
        ST_WR_DHI: begin
          hi_d    = word;
          state_d = ST_WR_DLO;
        end
        ST_WR_DLO: begin
          wr_en   = 1'b1;
          state_d = ST_IDLE;
        end
        ST_FWD: begin
          fwv_d  = 1'b1;
          fw_d   = word;
          left_d = left_q - 1'b1;
          if (left_q == 1) state_d = ST_IDLE;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      hi_q    <= '0;
      left_q  <= '0;
      err_q   <= 1'b0;
      fs_q    <= 1'b0;
      fid_q   <= '0;
      fwv_q   <= 1'b0;
      fw_q    <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      hi_q    <= hi_d;
      left_q  <= left_d;
      err_q   <= err_d;
      fs_q    <= fs_d;
      fid_q   <= fid_d;
      fwv_q   <= fwv_d;
      fw_q    <= fw_d;
    end
  end

  assign rd_addr      = word;
  assign wr_addr      = addr_q;
  assign wr_data      = {hi_q, word};
  assign err          = err_q;
  assign fwd_start    = fs_q;
  assign fwd_id       = fid_q;
  assign fwd_word_vld = fwv_q;
  assign fwd_word     = fw_q;

  AST_ERR_BACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> state_q == ST_IDLE); // R12
  AST_FWD_START_ARGS: assert property (@(posedge clk) disable iff (!rst_n)
    fs_q |-> state_q == ST_FWD && left_q != 0); // R11
  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && wr_en)); // R4

endmodule

// File: rtl/regcmd_edge_counter.sv
module regcmd_edge_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ch_async,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);

  logic             s1_q, s2_q, s3_q;
  logic             rise;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign rise = s2_q & ~s3_q;

  always_comb begin
    if (clr) cnt_d = CNT_W'(rise);
    else     cnt_d = cnt_q + CNT_W'(rise);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      s3_q  <= 1'b0;
      cnt_q <= '0;
    end else begin
      s1_q  <= ch_async;
      s2_q  <= s1_q;
      s3_q  <= s2_q;
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  AST_CLR_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !rise |=> cnt_q == '0); // R9
  AST_CLR_WITH_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    clr && rise |=> cnt_q == CNT_W'(1)); // R9
  AST_HOLD_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !rise |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/regcmd_regfile.sv
module regcmd_regfile
  import regcmd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] ch_in,
  input  logic [31:0]    cap_size,
  input  logic           rd_en,
  input  logic [15:0]    rd_addr,
  input  logic           wr_en,
  input  logic [15:0]    wr_addr,
  input  logic [31:0]    wr_data,
  output logic [31:0]    rdata,
  output logic [31:0]    ur0,
  output logic [31:0]    ur1,
  output logic [31:0]    ur2
);

  localparam int ADDR_STEP = 4;

  logic [CNT_W-1:0] cnt [NCH];
  logic [NCH-1:0]   clr;
  logic [31:0]      ur0_q, ur0_d, ur1_q, ur1_d, ur2_q, ur2_d;
  logic             we0, we1, we2;

  for (genvar g = 0; g < NCH; g++) begin : g_cnt
    regcmd_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .ch_async (ch_in[g]),
      .clr      (clr[g]),
      .cnt      (cnt[g])
    );
  end

  always_comb begin
    rdata = '0;
    clr   = '0;
    case (rd_addr)
      ADDR_IDA0, ADDR_IDA1: rdata = ID_VAL_A;
      ADDR_IDB:             rdata = ID_VAL_B;
      ADDR_CAP:             rdata = cap_size;
      ADDR_UR0:             rdata = ur0_q;
      ADDR_UR1:             rdata = ur1_q;
      ADDR_UR2:             rdata = ur2_q;
      default:              rdata = '0;
    endcase
    for (int i = 0; i < NCH; i++) begin
      if (rd_addr == ADDR_CNT0 + 16'(ADDR_STEP * i)) begin
        rdata  = 32'(cnt[i]);
        clr[i] = rd_en;
      end
    end
  end

  assign we0 = wr_en && (wr_addr == ADDR_UR0);
  assign we1 = wr_en && (wr_addr == ADDR_UR1);
  assign we2 = wr_en && (wr_addr == ADDR_UR2);

  always_comb begin
    ur0_d = we0 ? wr_data : ur0_q;
    ur1_d = we1 ? wr_data : ur1_q;
    ur2_d = we2 ? wr_data : ur2_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ur0_q <= '0;
      ur1_q <= '0;
      ur2_q <= '0;
    end else begin
      ur0_q <= ur0_d;
      ur1_q <= ur1_d;
      ur2_q <= ur2_d;
    end
  end

  assign ur0 = ur0_q;
  assign ur1 = ur1_q;
  assign ur2 = ur2_q;

  AST_UR0_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we0 |=> ur0_q == $past(wr_data)); // R5
  AST_UR_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ur0_q) && $stable(ur1_q) && $stable(ur2_q)); // R10

endmodule

// File: rtl/regcmd_rsp_ser.sv
module regcmd_rsp_ser
  import regcmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] data,
  output logic        rsp_valid,
  output logic [7:0]  rsp_byte
);

  logic        busy_q, busy_d;
  logic [1:0]  idx_q, idx_d;
  logic [31:0] data_q, data_d;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    data_d = data_q;
    if (busy_q) begin
      idx_d = idx_q + 2'd1;
      if (idx_q == 2'd3) busy_d = 1'b0;
    end
    if (start) begin
      busy_d = 1'b1;
      idx_d  = 2'd0;
      data_d = data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
      data_q <= data_d;
    end
  end

  assign rsp_valid = busy_q;
  assign rsp_byte  = lane_byte(data_q, idx_q);

  AST_START_NOT_MIDBURST: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy_q || idx_q == 2'd3); // R2
  AST_BURST_CONTINUES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_q) |=> busy_q); // R2

endmodule

// File: rtl/regcmd_decoder.sv
module regcmd_decoder
  import regcmd_pkg::*;
#(
  parameter int NCH   = 4,
  parameter int CNT_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [7:0]     in_byte,
  input  logic [NCH-1:0] ch_in,
  input  logic [31:0]    cap_size,
  output logic           rsp_valid,
  output logic [7:0]     rsp_byte,
  output logic           err,
  output logic           fwd_start,
  output logic [15:0]    fwd_id,
  output logic           fwd_word_vld,
  output logic [15:0]    fwd_word,
  output logic [31:0]    user_reg0,
  output logic [31:0]    user_reg1,
  output logic [31:0]    user_reg2
);

  logic        rst_m_q, rst_s_q;
  logic        word_vld;
  logic [15:0] word;
  logic        rd_en, wr_en;
  logic [15:0] rd_addr, wr_addr;
  logic [31:0] wr_data, rdata;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_q <= 1'b0;
      rst_s_q <= 1'b0;
    end else begin
      rst_m_q <= 1'b1;
      rst_s_q <= rst_m_q;
    end
  end

  regcmd_word_asm u_asm (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .in_valid (in_valid),
    .in_byte  (in_byte),
    .word_vld (word_vld),
    .word     (word)
  );

  regcmd_parser u_parse (
    .clk          (clk),
    .rst_n        (rst_s_q),
    .word_vld     (word_vld),
    .word         (word),
    .rd_en        (rd_en),
    .rd_addr      (rd_addr),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .err          (err),
    .fwd_start    (fwd_start),
    .fwd_id       (fwd_id),
    .fwd_word_vld (fwd_word_vld),
    .fwd_word     (fwd_word)
  );

  regcmd_regfile #(.NCH(NCH), .CNT_W(CNT_W)) u_rf (
    .clk      (clk),
    .rst_n    (rst_s_q),
    .ch_in    (ch_in),
    .cap_size (cap_size),
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .rdata    (rdata),
    .ur0      (user_reg0),
    .ur1      (user_reg1),
    .ur2      (user_reg2)
  );

  regcmd_rsp_ser u_ser (
    .clk       (clk),
    .rst_n     (rst_s_q),
    .start     (rd_en),
    .data      (rdata),
    .rsp_valid (rsp_valid),
    .rsp_byte  (rsp_byte)
  );

  AST_READ_STARTS_RSP: assert property (@(posedge clk) disable iff (!rst_s_q)
    rd_en |=> rsp_valid); // R2
  AST_WRITE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_s_q)
    wr_en && !rsp_valid |=> !rsp_valid); // R4

endmodule

// File: tb/regcmd_decoder_tb.sv
`timescale 1ns/1ps
module regcmd_decoder_tb;

  localparam int NCH = 4;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [7:0]     in_byte;
  logic [NCH-1:0] ch_in;
  logic [31:0]    cap_size;
  logic           rsp_valid;
  logic [7:0]     rsp_byte;
  logic           err;
  logic           fwd_start;
  logic [15:0]    fwd_id;
  logic           fwd_word_vld;
  logic [15:0]    fwd_word;
  logic [31:0]    user_reg0, user_reg1, user_reg2;

  always #2.5 clk = ~clk;

  regcmd_decoder #(.NCH(NCH), .CNT_W(32)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .ch_in(ch_in), .cap_size(cap_size), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte),
    .err(err), .fwd_start(fwd_start), .fwd_id(fwd_id), .fwd_word_vld(fwd_word_vld),
    .fwd_word(fwd_word), .user_reg0(user_reg0), .user_reg1(user_reg1), .user_reg2(user_reg2)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Output monitors
  int         rsp_total = 0;
  logic [7:0] rsp_buf [256];
  int         err_total = 0;
  int         fs_total  = 0;
  logic [15:0] fs_last_id = '0;
  int         fw_total  = 0;
  logic [15:0] fw_buf [8];

  always @(negedge clk) begin
    if (rsp_valid) begin
      rsp_buf[rsp_total % 256] = rsp_byte;
      rsp_total++;
    end
    if (err) err_total++;
    if (fwd_start) begin
      fs_total++;
      fs_last_id = fwd_id;
    end
    if (fwd_word_vld) begin
      fw_buf[fw_total % 8] = fwd_word;
      fw_total++;
    end
  end

  // Reference model state
  logic [31:0] m_ur0 = '0, m_ur1 = '0, m_ur2 = '0;

  function automatic logic [31:0] exp_read(input logic [15:0] a);
    case (a)
      16'h10B0, 16'h10BC: return 32'h1234_5678;
      16'h10B8:           return 32'h8765_4321;
      16'h1078:           return cap_size;
      16'h10B4:           return m_ur0;
      16'h1074:           return m_ur1;
      16'h107C:           return m_ur2;
      default:            return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    in_valid = 1'b1;
    in_byte  = b;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_word(input logic [15:0] w);
    send_byte(w[7:0]);
    send_byte(w[15:8]);
  endtask

  task automatic do_write(input logic [15:0] a, input logic [31:0] d);
    int base;
    base = rsp_total;
    send_word(16'h0002);
    send_word(a);
    send_word(d[31:16]);
    send_word(d[15:0]);
    idle(8);
    chk("R4 write gives no response bytes", 32'(rsp_total - base), 32'd0);
    case (a)
      16'h10B4: m_ur0 = d;
      16'h1074: m_ur1 = d;
      16'h107C: m_ur2 = d;
      default: ;
    endcase
  endtask

  // Collects four response bytes and reassembles them per R3
  task automatic collect(input int base, output logic [31:0] d);
    idle(8);
    chk("R2 four response bytes", 32'(rsp_total - base), 32'd4);
    d = {rsp_buf[(base+1)%256], rsp_buf[base%256], rsp_buf[(base+3)%256], rsp_buf[(base+2)%256]};
  endtask

  task automatic do_read(input logic [15:0] a, output logic [31:0] d);
    int base;
    base = rsp_total;
    send_word(16'h0001);
    send_word(a);
    collect(base, d);
  endtask

  task automatic pulse(input int ch);
    @(negedge clk);
    ch_in[ch] = 1'b1;
    repeat (3) @(negedge clk);
    ch_in[ch] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // Read of counter ch with the channel rising alongside byte number rise_at (0..3)
  task automatic read_with_rise(input int ch, input int rise_at, output logic [31:0] d);
    int base;
    logic [15:0] a;
    logic [7:0] bytes [4];
    a = 16'h10C0 + 16'(4*ch);
    bytes[0] = 8'h01; bytes[1] = 8'h00; bytes[2] = a[7:0]; bytes[3] = a[15:8];
    base = rsp_total;
    for (int k = 0; k < 4; k++) begin
      send_byte(bytes[k]);
      if (k == rise_at) ch_in[ch] = 1'b1;
    end
    collect(base, d);
    ch_in[ch] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    logic [31:0] rd;
    logic [15:0] addr;
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_byte  = '0;
    ch_in    = '0;
    cap_size = 32'h0003_F00D;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // Reset state
    chk("R5 reset user_reg0", user_reg0, 32'h0);
    chk("R5 reset user_reg1", user_reg1, 32'h0);
    chk("R5 reset user_reg2", user_reg2, 32'h0);
    chk("R2 no response after reset", {31'b0, rsp_valid}, 32'h0);
    chk("R12 no err after reset", {31'b0, err}, 32'h0);

    // Identity constants and capture size (R6, R7)
    do_read(16'h10B0, rd); chk("R6 id 10B0", rd, 32'h1234_5678);
    do_read(16'h10BC, rd); chk("R6 id 10BC", rd, 32'h1234_5678);
    do_read(16'h10B8, rd); chk("R6 id 10B8", rd, 32'h8765_4321);
    do_read(16'h1078, rd); chk("R7 capture size", rd, 32'h0003_F00D);
    cap_size = 32'hA1B2_C3D4;
    do_read(16'h1078, rd); chk("R7 capture size follows input", rd, 32'hA1B2_C3D4);

    // Byte order with distinct bytes (R1, R3)
    do_write(16'h10B4, 32'h1122_3344);
    chk("R3 write byte order on user_reg0", user_reg0, 32'h1122_3344);
    do_read(16'h10B4, rd);
    chk("R3 response byte order", rd, 32'h1122_3344);
    chk("R1 first response byte is d[23:16]", {24'b0, rsp_buf[(rsp_total-4)%256]}, 32'h22);

    // Sweep: write a pattern everywhere, then read back (R5, R6, R7, R8, R10)
    for (int i = 0; i < 28; i++) begin
      addr = 16'h1070 + 16'(4*i);
      do_write(addr, 32'hA500_0000 | 32'(addr) | (32'(i) << 16));
    end
    do_write(16'h0000, 32'hDEAD_0001);
    do_write(16'hFFFF, 32'hDEAD_0002);
    do_write(16'h10B5, 32'hDEAD_0003);
    chk("R5 user_reg0 after sweep", user_reg0, m_ur0);
    chk("R5 user_reg1 after sweep", user_reg1, m_ur1);
    chk("R5 user_reg2 after sweep", user_reg2, m_ur2);
    for (int i = 0; i < 28; i++) begin
      addr = 16'h1070 + 16'(4*i);
      do_read(addr, rd);
      chk("R10 map sweep (R5 R6 R7 R8 values)", rd, exp_read(addr));
    end
    do_read(16'h0000, rd); chk("R10 unmapped 0000", rd, 32'h0);
    do_read(16'hFFFF, rd); chk("R10 unmapped FFFF", rd, 32'h0);
    do_read(16'h10B5, rd); chk("R10 unmapped 10B5", rd, 32'h0);

    // Counters (R8, R9)
    for (int c = 0; c < NCH; c++)
      for (int p = 0; p < 2*c + 3; p++) pulse(c);
    for (int c = 0; c < NCH; c++) begin
      do_read(16'h10C0 + 16'(4*c), rd);
      chk("R8 edge count per channel", rd, 32'(2*c + 3));
      do_read(16'h10C0 + 16'(4*c), rd);
      chk("R9 counter cleared by read", rd, 32'h0);
    end

    // Coincident edge and clearing read (R9)
    pulse(1); pulse(1);
    read_with_rise(1, 2, rd);
    chk("R9 coincident read returns old count", rd, 32'd2);
    do_read(16'h10C4, rd);
    chk("R9 coincident edge kept as 1", rd, 32'd1);
    pulse(2); pulse(2);
    read_with_rise(2, 1, rd);
    chk("R9 earlier edge counted before clear", rd, 32'd3);
    do_read(16'h10C8, rd);
    chk("R9 earlier edge cleared", rd, 32'd0);

    // Forwarded commands (R11)
    send_word(16'h0006);
    for (int k = 0; k < 4; k++) send_word(16'h6000 + 16'(k));
    idle(4);
    chk("R11 mem fwd_start count", 32'(fs_total), 32'd1);
    chk("R11 mem fwd_id", {16'b0, fs_last_id}, 32'h0006);
    chk("R11 mem argument count", 32'(fw_total), 32'd4);
    for (int k = 0; k < 4; k++)
      chk("R11 mem argument value", {16'b0, fw_buf[k]}, 32'h6000 + 32'(k));
    send_word(16'h0008);
    send_word(16'h000A);
    send_word(16'h0000);
    idle(4);
    chk("R11 poll fwd_start count", 32'(fs_total), 32'd2);
    chk("R11 poll fwd_id", {16'b0, fs_last_id}, 32'h0008);
    chk("R11 poll argument count", 32'(fw_total), 32'd6);
    do_read(16'h10B8, rd);
    chk("R11 parser idle after forwarding", rd, 32'h8765_4321);
    chk("R11 no err on forwarded ids", 32'(err_total), 32'd0);

    // Unknown identifiers (R12)
    send_word(16'h0003);
    idle(3);
    chk("R12 err pulse on 0003", 32'(err_total), 32'd1);
    send_word(16'h0007);
    idle(3);
    chk("R12 err pulse on 0007", 32'(err_total), 32'd2);
    do_read(16'h10B0, rd);
    chk("R12 next word is a new identifier", rd, 32'h1234_5678);
    chk("R12 no forwarding on unknown ids", 32'(fs_total), 32'd2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

endmodule